// File: doc/BRIEF.md
# AFSK Tone Transmitter

The block turns a stream of bytes into audio-frequency shift keying: a sequence of 8-bit sine samples at a fixed sample rate, suitable for driving a DAC directly. Bytes enter over a valid/ready handshake into a small queue. Once the queue holds something and the block is idle, it opens a transmission with a run of flag bytes, serialises the queued data least significant bit first, and closes with more flag bytes when the queue runs dry at a byte boundary.

Bits are NRZI-coded onto two tones. A zero bit swaps the tone and a one bit keeps it. The tone is set by the step added to a 16-bit phase accumulator once per sample; the top nine accumulator bits address a 512-entry full-wave sine table. Swapping only the step keeps the phase continuous across tone changes. Inside data, a zero is inserted after five consecutive ones. Flag bytes are never stuffed, and they clear the run-of-ones count. If bytes arrive during the trailer, data resumes without a new preamble. Otherwise the block finishes the last bit, drops its sending flag and parks the output at mid-scale.

Top module: `afsk_tx`

## Requirements
- R1: A byte is taken from data_i on a clock edge where valid_i and ready_o are both high. ready_o is low while the queue holds FIFO_DEPTH bytes, and a byte offered while ready_o is low is not accepted and never appears in the output.
- R2: Out of reset and whenever sending_o is low, sample_o is 0x80, sample_stb_o is low and ready_o is high while the queue has room.
- R3: A transmission starts when the block is idle and the queue is non-empty. sending_o rises, the accumulator is cleared and the step is set to the mark value. The first sample, 0x80, is strobed on the second cycle after sending_o rises.
- R4: While sending, sample_stb_o pulses for one cycle every CLKS_PER_SAMPLE clocks, and sample_o changes only with a strobe. Each bit spans SAMPLE_HZ/BAUD samples (8 by default).
- R5: Each strobed sample equals round(128 + 127·sin(2π·i/512)) within ±1, where i is bits [15:7] of the accumulator. The 16-bit accumulator then advances by the current step, wraps modulo 2^16, and is never cleared on a tone change.
- R6: The step for a tone is round(65536 × tone_hz / SAMPLE_HZ). By default this gives a mark step of 8192 (1200 Hz) and a space step of 15019 (2200 Hz).
- R7: Bits are sent least significant bit first. At the first sample of a bit, a zero swaps the step between mark and space and a one keeps it.
- R8: Every transmission opens with PRE_FLAGS flag bytes (0x7E) before the first data byte. When the queue is empty at a data byte boundary, TRAIL_FLAGS flag bytes follow. The defaults are 68 and 15, which is 450 ms and 100 ms at 1200 baud.
- R9: Inside data bytes, a zero bit is inserted after five consecutive one bits, counting across byte boundaries. Every sent zero and every flag byte resets the count, and flag bytes never receive a stuffed bit.
- R10: When the trailer ends with an empty queue, the last bit still gets all its samples. After that, sending_o falls and sample_o returns to 0x80 with no further strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | 8 | Byte to transmit |
| valid_i | input | 1 | data_i holds a byte |
| ready_o | output | 1 | Queue can accept a byte |
| sample_o | output | 8 | Unsigned sine sample, 0x80 at rest |
| sample_stb_o | output | 1 | One-cycle pulse when sample_o takes a new sample |
| sending_o | output | 1 | Transmission in progress |

## Verification
The bench compares every strobed sample of whole frames against a waveform it computes from a floating-point sine and its own model of the framing, NRZI and stuffing. The patterns are chosen so that each of the following faults changes the waveform or the sample count: a stuffed zero missing, stuffing applied to the trailer flags, a missed stuff at a byte boundary (0xF8 followed by 0x1F), a wrong space step, a tone switched on ones, or an accumulator reset on a tone change. All-ones and repeated 0x7E data bytes catch stuffing that forgets to count across bytes or that treats data 0x7E as a flag. A full queue with valid_i held high catches a queue that overwrites or accepts while ready_o is low: the extra byte would lengthen the frame. The end of each frame is checked for a lost final bit and for an output left off mid-scale.

// File: rtl/afsk_tx_pkg.sv
`timescale 1ns/1ps
package afsk_tx_pkg;
  localparam int unsigned ACC_W  = 16;
  localparam int unsigned ROM_AW = 9;
  localparam int unsigned HALF   = 2 ** (ROM_AW - 1);
  localparam logic [7:0] FLAG_BYTE = 8'h7E;
  localparam logic [7:0] MID_SCALE = 8'h80;

  typedef enum logic [1:0] {ST_IDLE, ST_PRE, ST_DATA, ST_TRAIL} fr_state_e;

  function automatic logic [ACC_W-1:0] tone_step(input int unsigned tone_hz,
                                                 input int unsigned rate_hz);
    longint unsigned num;
    num = (64'(tone_hz) << ACC_W) + 64'(rate_hz / 2);
    return ACC_W'(num / 64'(rate_hz));
  endfunction

  // rational half-wave sine approximation, error well under one code
  function automatic logic [7:0] sine_code(input logic [ROM_AW-1:0] idx);
    int unsigned k, p, den, mag;
    k   = 32'(idx[ROM_AW-2:0]);
    p   = k * (HALF - k);
    den = 5 * HALF * HALF - 4 * p;
    mag = (127 * 32 * p + den) / (2 * den);
    return idx[ROM_AW-1] ? 8'(128 - mag) : 8'(128 + mag);
  endfunction
endpackage

// File: rtl/afsk_tx_sine_rom.sv
`timescale 1ns/1ps
module afsk_tx_sine_rom
  import afsk_tx_pkg::*;
(
  input  logic [ROM_AW-1:0] idx_i,
  output logic [7:0]        code_o
);
  localparam int unsigned ENTRIES = 2 ** ROM_AW;

  logic [7:0] rom [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_rom
    assign rom[g] = sine_code(ROM_AW'(g));
  end

  assign code_o = rom[idx_i];
endmodule

// File: rtl/afsk_tx_fifo.sv
`timescale 1ns/1ps
module afsk_tx_fifo #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned W     = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] data_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign data_o  = mem[rd_q];

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
      if (do_pop)  rd_q <= (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/afsk_tx_framer.sv
`timescale 1ns/1ps
module afsk_tx_framer
  import afsk_tx_pkg::*;
#(
  parameter int unsigned PRE_FLAGS   = 68,
  parameter int unsigned TRAIL_FLAGS = 15
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       fifo_empty_i,
  input  logic [7:0] fifo_data_i,
  output logic       pop_o,
  input  logic       run_i,
  input  logic       take_i,
  output logic       active_o,
  output logic       bit_o
);
  localparam int unsigned FMAX  = (PRE_FLAGS > TRAIL_FLAGS) ? PRE_FLAGS : TRAIL_FLAGS;
  localparam int unsigned CNT_W = $clog2(FMAX + 1);

  fr_state_e        state_q, ld_state;
  logic [7:0]       shreg_q, ld_byte;
  logic [2:0]       bit_idx_q, ones_q;
  logic             byte_empty_q, stuff_q;
  logic [CNT_W-1:0] fcnt_q, ld_fcnt;
  logic             is_data, new_stuff, do_load, do_start, do_take;

  assign is_data   = (state_q == ST_DATA);
  assign active_o  = (state_q != ST_IDLE);
  assign bit_o     = stuff_q ? 1'b0 : shreg_q[0];
  assign do_take   = take_i && active_o;
  assign new_stuff = !stuff_q && is_data && shreg_q[0] && (ones_q == 3'd4);
  assign do_start  = (state_q == ST_IDLE) && !fifo_empty_i && !run_i;
  assign do_load   = do_take && (stuff_q ? byte_empty_q
                                         : (bit_idx_q == 3'd7 && !new_stuff));

  // source of the next byte once the current one is exhausted
  always_comb begin
    ld_state = state_q;
    ld_byte  = FLAG_BYTE;
    ld_fcnt  = '0;
    pop_o    = 1'b0;
    unique case (state_q)
      ST_PRE: begin
        if (fcnt_q != CNT_W'(PRE_FLAGS - 1)) begin
          ld_fcnt = fcnt_q + 1'b1;
        end else if (!fifo_empty_i) begin
          ld_state = ST_DATA;
          ld_byte  = fifo_data_i;
          pop_o    = do_load;
        end else begin
          ld_state = ST_TRAIL;
        end
      end
      ST_DATA: begin
        if (!fifo_empty_i) begin
          ld_byte = fifo_data_i;
          pop_o   = do_load;
        end else begin
          ld_state = ST_TRAIL;
        end
      end
      ST_TRAIL: begin
        if (fcnt_q != CNT_W'(TRAIL_FLAGS - 1)) begin
          ld_fcnt = fcnt_q + 1'b1;
        end else if (!fifo_empty_i) begin
          ld_state = ST_DATA;
          ld_byte  = fifo_data_i;
          pop_o    = do_load;
        end else begin
          ld_state = ST_IDLE;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      shreg_q      <= FLAG_BYTE;
      bit_idx_q    <= '0;
      ones_q       <= '0;
      byte_empty_q <= 1'b0;
      stuff_q      <= 1'b0;
      fcnt_q       <= '0;
    end else if (do_start) begin
      state_q      <= ST_PRE;
      shreg_q      <= FLAG_BYTE;
      bit_idx_q    <= '0;
      ones_q       <= '0;
      byte_empty_q <= 1'b0;
      stuff_q      <= 1'b0;
      fcnt_q       <= '0;
    end else if (do_take) begin
      if (stuff_q) begin
        stuff_q <= 1'b0;
        ones_q  <= '0;
      end else begin
        shreg_q   <= shreg_q >> 1;
        bit_idx_q <= bit_idx_q + 1'b1;
        if (!is_data || !shreg_q[0]) begin
          ones_q <= '0;
        end else if (new_stuff) begin
          stuff_q <= 1'b1;
          ones_q  <= '0;
        end else begin
          ones_q <= ones_q + 1'b1;
        end
        if (bit_idx_q == 3'd7) byte_empty_q <= new_stuff;
      end
      if (do_load) begin
        state_q      <= ld_state;
        shreg_q      <= ld_byte;
        bit_idx_q    <= '0;
        byte_empty_q <= 1'b0;
        fcnt_q       <= ld_fcnt;
      end
    end
  end
endmodule

// File: rtl/afsk_tx_synth.sv
`timescale 1ns/1ps
module afsk_tx_synth
  import afsk_tx_pkg::*;
#(
  parameter int unsigned     CLKS_PER_SAMPLE = 5208,
  parameter int unsigned     SAMPLES_PER_BIT = 8,
  parameter logic [ACC_W-1:0] MARK_STEP      = 16'd8192,
  parameter logic [ACC_W-1:0] SPACE_STEP     = 16'd15019
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       active_i,
  input  logic       bit_i,
  output logic       take_o,
  output logic       running_o,
  output logic [7:0] sample_o,
  output logic       stb_o
);
  localparam int unsigned DIV_W  = (CLKS_PER_SAMPLE > 1) ? $clog2(CLKS_PER_SAMPLE) : 1;
  localparam int unsigned SCNT_W = (SAMPLES_PER_BIT > 1) ? $clog2(SAMPLES_PER_BIT) : 1;

  logic              run_q, stb_q;
  logic [DIV_W-1:0]  div_q;
  logic [SCNT_W-1:0] scnt_q;
  logic [ACC_W-1:0]  acc_q, inc_q, bit_inc, step;
  logic [7:0]        sample_q, code;
  logic              tick, bit_start;

  assign tick      = run_q && (div_q == DIV_W'(CLKS_PER_SAMPLE - 1));
  assign bit_start = tick && (scnt_q == '0);
  assign take_o    = bit_start && active_i;
  // NRZI: a zero swaps tones, phase carries on
  assign bit_inc   = bit_i ? inc_q : ((inc_q == MARK_STEP) ? SPACE_STEP : MARK_STEP);
  assign step      = take_o ? bit_inc : inc_q;

  afsk_tx_sine_rom u_rom (
    .idx_i  (acc_q[ACC_W-1 -: ROM_AW]),
    .code_o (code)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q    <= 1'b0;
      stb_q    <= 1'b0;
      div_q    <= '0;
      scnt_q   <= '0;
      acc_q    <= '0;
      inc_q    <= MARK_STEP;
      sample_q <= MID_SCALE;
    end else begin
      stb_q <= 1'b0;
      if (!run_q) begin
        if (active_i) begin
          run_q  <= 1'b1;
          div_q  <= DIV_W'(CLKS_PER_SAMPLE - 1);
          scnt_q <= '0;
          acc_q  <= '0;
          inc_q  <= MARK_STEP;
        end
      end else if (bit_start && !active_i) begin
        run_q    <= 1'b0;
        sample_q <= MID_SCALE;
      end else begin
        div_q <= tick ? '0 : div_q + 1'b1;
        if (tick) begin
          stb_q    <= 1'b1;
          sample_q <= code;
          acc_q    <= acc_q + step;
          inc_q    <= step;
          scnt_q   <= (scnt_q == SCNT_W'(SAMPLES_PER_BIT - 1)) ? '0 : scnt_q + 1'b1;
        end
      end
    end
  end

  assign running_o = run_q;
  assign sample_o  = sample_q;
  assign stb_o     = stb_q;
endmodule

// File: rtl/afsk_tx.sv
`timescale 1ns/1ps
module afsk_tx
  import afsk_tx_pkg::*;
#(
  parameter int unsigned CLKS_PER_SAMPLE = 5208,
  parameter int unsigned SAMPLE_HZ       = 9600,
  parameter int unsigned BAUD            = 1200,
  parameter int unsigned MARK_HZ         = 1200,
  parameter int unsigned SPACE_HZ        = 2200,
  parameter int unsigned PRE_FLAGS       = 68,
  parameter int unsigned TRAIL_FLAGS     = 15,
  parameter int unsigned FIFO_DEPTH      = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [7:0] data_i,
  input  logic       valid_i,
  output logic       ready_o,
  output logic [7:0] sample_o,
  output logic       sample_stb_o,
  output logic       sending_o
);
  localparam int unsigned      SAMPLES_PER_BIT = SAMPLE_HZ / BAUD;
  localparam logic [ACC_W-1:0] MARK_STEP       = tone_step(MARK_HZ, SAMPLE_HZ);
  localparam logic [ACC_W-1:0] SPACE_STEP      = tone_step(SPACE_HZ, SAMPLE_HZ);

  logic       fifo_empty, fifo_full, pop;
  logic [7:0] fifo_data;
  logic       active, cur_bit, take, running;

  afsk_tx_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (valid_i),
    .data_i  (data_i),
    .pop_i   (pop),
    .data_o  (fifo_data),
    .empty_o (fifo_empty),
    .full_o  (fifo_full)
  );

  afsk_tx_framer #(.PRE_FLAGS(PRE_FLAGS), .TRAIL_FLAGS(TRAIL_FLAGS)) u_framer (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .fifo_empty_i (fifo_empty),
    .fifo_data_i  (fifo_data),
    .pop_o        (pop),
    .run_i        (running),
    .take_i       (take),
    .active_o     (active),
    .bit_o        (cur_bit)
  );

  afsk_tx_synth #(
    .CLKS_PER_SAMPLE (CLKS_PER_SAMPLE),
    .SAMPLES_PER_BIT (SAMPLES_PER_BIT),
    .MARK_STEP       (MARK_STEP),
    .SPACE_STEP      (SPACE_STEP)
  ) u_synth (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .active_i  (active),
    .bit_i     (cur_bit),
    .take_o    (take),
    .running_o (running),
    .sample_o  (sample_o),
    .stb_o     (sample_stb_o)
  );

  assign ready_o   = !fifo_full;
  assign sending_o = running;
endmodule

// File: rtl/afsk_tx_chk.sv
`timescale 1ns/1ps
module afsk_tx_chk #(
  parameter int unsigned CLKS_PER_SAMPLE = 2
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       valid_i,
  input logic       ready_o,
  input logic [7:0] sample_o,
  input logic       sample_stb_o,
  input logic       sending_o
);
  AST_IDLE_MID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sending_o |-> (sample_o == 8'h80)); // R2

  AST_IDLE_NO_STB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sending_o |-> !sample_stb_o); // R2

  AST_START_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sending_o) |=> (sample_stb_o && sample_o == 8'h80)); // R3

  AST_HOLD_BETWEEN_STB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sending_o && !sample_stb_o) |-> $stable(sample_o)); // R4

  AST_END_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sending_o) |-> (!sample_stb_o && sample_o == 8'h80)); // R10

  AST_FULL_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ready_o && valid_i && !sending_o) |=> !ready_o); // R1

  if (CLKS_PER_SAMPLE > 1) begin : g_gap
    AST_STB_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sample_stb_o |=> !sample_stb_o); // R4
  end
endmodule

bind afsk_tx afsk_tx_chk #(.CLKS_PER_SAMPLE(CLKS_PER_SAMPLE)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .valid_i      (valid_i),
  .ready_o      (ready_o),
  .sample_o     (sample_o),
  .sample_stb_o (sample_stb_o),
  .sending_o    (sending_o)
);

// File: tb/afsk_tx_tb.sv
`timescale 1ns/1ps
module afsk_tx_tb;
  localparam int CLKS  = 4;
  localparam int PRE   = 2;
  localparam int TRAIL = 1;
  localparam int SPB   = 8;
  localparam int MARK  = 8192;   // R6
  localparam int SPACE = 15019;  // R6
  localparam int NVEC  = 6;

  // {length, byte0, byte1, byte2, byte3}
  localparam logic [39:0] VECS [NVEC] = '{
    {8'd1, 8'h00, 8'h00, 8'h00, 8'h00},
    {8'd1, 8'hFF, 8'h00, 8'h00, 8'h00},
    {8'd2, 8'h7E, 8'h7E, 8'h00, 8'h00},
    {8'd2, 8'hF8, 8'h1F, 8'h00, 8'h00},
    {8'd3, 8'h55, 8'hAA, 8'h3C, 8'h00},
    {8'd4, 8'hFF, 8'hFF, 8'h01, 8'h80}
  };

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] data_i = 8'h00;
  logic       valid_i = 1'b0;
  logic       ready_o, sample_stb_o, sending_o;
  logic [7:0] sample_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  int  cap [1024];
  int  cap_n = 0;
  bit  cap_en = 1'b0;
  int  cyc = 0;
  int  last_stb = 0;
  int  gap_bad = 0;

  bit  ebits [512];
  int  n_bits;
  int  ones;

  afsk_tx #(
    .CLKS_PER_SAMPLE (CLKS),
    .PRE_FLAGS       (PRE),
    .TRAIL_FLAGS     (TRAIL),
    .FIFO_DEPTH      (4)
  ) u_dut (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .data_i       (data_i),
    .valid_i      (valid_i),
    .ready_o      (ready_o),
    .sample_o     (sample_o),
    .sample_stb_o (sample_stb_o),
    .sending_o    (sending_o)
  );

  always #10 clk_i = ~clk_i;

  always @(negedge clk_i) begin
    cyc <= cyc + 1;
    if (cap_en && sample_stb_o) begin
      if (cap_n > 0 && (cyc - last_stb) != CLKS) gap_bad <= gap_bad + 1;
      last_stb <= cyc;
      if (cap_n < 1024) cap[cap_n] <= int'(sample_o);
      cap_n <= cap_n + 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int sine_exp(input int idx);
    real v;
    v = 128.0 + 127.0 * $sin(2.0 * 3.14159265358979 * real'(idx) / 512.0);
    return int'(v);
  endfunction

  task automatic add_byte(input logic [7:0] b, input bit is_flag);
    for (int i = 0; i < 8; i++) begin
      ebits[n_bits] = b[i];
      n_bits++;
      if (is_flag || !b[i]) ones = 0;
      else begin
        ones++;
        if (ones == 5) begin
          ebits[n_bits] = 1'b0;
          n_bits++;
          ones = 0;
        end
      end
    end
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk_i);
    while (!ready_o) @(negedge clk_i);
    valid_i = 1'b1;
    data_i  = b;
    @(negedge clk_i);
    valid_i = 1'b0;
  endtask

  task automatic run_frame(input logic [39:0] v, input int vi);
    int len, acc, inc, bad, first_bad_a, first_bad_e, k;
    len = int'(v[39:32]);
    n_bits = 0;
    ones = 0;
    for (int i = 0; i < PRE; i++) add_byte(8'h7E, 1'b1);
    for (int i = 0; i < len; i++) add_byte(v[31-8*i -: 8], 1'b0);
    for (int i = 0; i < TRAIL; i++) add_byte(8'h7E, 1'b1);

    cap_n = 0;
    gap_bad = 0;
    cap_en = 1'b1;
    for (int i = 0; i < len; i++) push(v[31-8*i -: 8]);
    if (len == 4) begin
      // queue full: offered byte must be ignored
      check(!ready_o, "R1 ready low when full", int'(ready_o), 0);
      @(negedge clk_i);
      valid_i = 1'b1;
      data_i  = 8'hC3;
      repeat (3) @(negedge clk_i);
      valid_i = 1'b0;
    end
    wait (sending_o);
    wait (!sending_o);
    @(negedge clk_i);
    @(negedge clk_i);
    cap_en = 1'b0;

    check(sample_o == 8'h80 && !sample_stb_o, "R10 mid-scale after frame",
          int'(sample_o), 128);
    check(cap_n == n_bits * SPB, "R4/R8 sample count", cap_n, n_bits * SPB);
    check(gap_bad == 0, "R4 strobe spacing", gap_bad, 0);
    check(cap_n > 0 && cap[0] == 128, "R3 first sample", cap[0], 128);

    acc = 0;
    inc = MARK;
    bad = 0;
    first_bad_a = 0;
    first_bad_e = 0;
    k = 0;
    for (int b = 0; b < n_bits; b++) begin
      if (!ebits[b]) inc = (inc == MARK) ? SPACE : MARK;
      for (int s = 0; s < SPB; s++) begin
        int e;
        e = sine_exp(acc >> 7);
        if (k < cap_n && (cap[k] - e > 1 || e - cap[k] > 1)) begin
          if (bad == 0) begin
            first_bad_a = cap[k];
            first_bad_e = e;
          end
          bad++;
        end
        acc = (acc + inc) & 16'hFFFF;
        k++;
      end
    end
    if (bad != 0) $display("  vector %0d: first mismatch shown, %0d samples off", vi, bad);
    check(bad == 0, "R5/R7/R9 waveform", first_bad_a, first_bad_e);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R2: reset state
    check(sample_o == 8'h80, "R2 reset sample", int'(sample_o), 128);
    check(!sample_stb_o && !sending_o, "R2 reset idle",
          int'({sample_stb_o, sending_o}), 0);
    check(ready_o, "R1 ready after reset", int'(ready_o), 1);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    check(!sending_o && sample_o == 8'h80, "R2 idle without data",
          int'(sample_o), 128);

    for (int vi = 0; vi < NVEC; vi++) run_frame(VECS[vi], vi);

    // R6: second sample of a frame follows the space step (first flag bit is zero)
    check(cap[1] - sine_exp(SPACE >> 7) <= 1 && sine_exp(SPACE >> 7) - cap[1] <= 1,
          "R6 space step", cap[1], sine_exp(SPACE >> 7));

    // R2/R1: idle and empty again after all frames
    repeat (20) @(negedge clk_i);
    check(!sending_o && ready_o && sample_o == 8'h80, "R2 idle after frames",
          int'(sample_o), 128);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R4 actual=%0d expected=%0d", cyc, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule